// File: doc/BRIEF.md
# Packed-Word JTAG Bit Player

This block plays a prepared bit stream into a JTAG chain. A host first writes a small buffer of words through a word-write port. Word 0 holds the number of bit pairs to play. Each later word packs sixteen pairs of test-mode-select and test-data-in bits. After a start pulse the block generates the test clock itself. Each clock phase lasts a programmable number of system cycles. The block presents one pair per test-clock period and samples test-data-out a programmable number of cycles after each rising edge.

The sampled bits are collected in groups of sixteen. Each group is sent out as a result word, with a one-cycle valid strobe and zeros in the upper half. A short final group is sent out as well, zero-padded. A busy level covers the run, and a done pulse marks its end. A bit count of zero finishes at once, without any clock pulse.

Top module: `jtag_word_player`

## Requirements
- R1: While reset is held and just after it, `tck`, `tms`, `tdi`, `busy`, `done` and `res_valid` are all 0.
- R2: A start pulse while idle plays exactly min(word 0, capacity) TCK pulses with `busy` high. The edge that drops TCK after the last pulse also lowers `busy` and raises `done` for one cycle.
- R3: Bit pair b is taken from buffer word 1 + b/16. TDI is at bit 2·(b mod 16) and TMS is at bit 2·(b mod 16)+1. After every 16 pairs the read moves on to the next word.
- R4: TMS and TDI change only while TCK is low. They are set at the start of each low phase and stay stable across the rising edge of TCK.
- R5: Each high phase and each low phase of TCK lasts `half_period` clock cycles. A value of 0 acts as 1.
- R6: TDO is sampled at the (d+1)-th clock edge after TCK rises. Here d is `sample_delay`, clamped to `half_period`−1.
- R7: The j-th sampled TDO bit of a group goes to bit j of the result word, for j from 0 to 15. Bits 31:16 are 0. `res_valid` is high for one cycle, in the cycle after the edge that samples the 16th bit of the group.
- R8: A final group of fewer than 16 bits is sent out, zero-padded above its last bit. `res_valid` rises in the cycle after the last bit is sampled.
- R9: A bit count of 0 gives `done` in the cycle after start. It gives no TCK pulse, no `busy` and no result word.
- R10: A bit count above the capacity of (DEPTH−1)·16 pairs is clamped to that capacity.
- R11: A start pulse or a buffer write that arrives while `busy` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer word write enable |
| wr_addr | input | AW | Buffer word index (0 = bit count) |
| wr_data | input | WORD_W | Word to write |
| start | input | 1 | Begin playing the buffer |
| half_period | input | HP_W | Cycles per TCK phase |
| sample_delay | input | DLY_W | Cycles from TCK rise to TDO sample, minus one |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to chain |
| tdo | input | 1 | Test data from chain |
| res_word | output | WORD_W | Packed TDO result |
| res_valid | output | 1 | One-cycle strobe for `res_word` |

## Verification
The start edge raises `busy` and starts the first low phase. TCK first rises `half_period` edges later, and after that it changes every `half_period` edges. TDO is captured d+1 edges after a rise, and the result strobe follows that capture by one cycle. `done` comes on the same edge as the last falling TCK. The bench drives its inputs and samples on the falling clock edge. It counts those edges from each TCK change, so every check falls one half cycle after the edge that should have produced the result. TDO is driven correctly only in the falling-edge slot that matches the expected sample edge and is inverted in every other slot, so a sample taken one edge early or late gives a wrong result word.

// File: rtl/jwp_pkg.sv
package jwp_pkg;
   typedef enum logic [0:0] {
      JWP_IDLE = 1'b0,
      JWP_RUN  = 1'b1
   } jwp_state_e;

   function automatic int unsigned jwp_capacity(input int unsigned depth, input int unsigned word_w);
      return (depth - 1) * (word_w / 2);
   endfunction
endpackage

// File: rtl/jwp_word_buf.sv
module jwp_word_buf #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 16,
   parameter int BIDX_W = 8,
   localparam int AW     = $clog2(DEPTH),
   localparam int PAIR_W = $clog2(WORD_W / 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              lock,
   input  logic [BIDX_W-1:0] rd_bit,
   output logic [WORD_W-1:0] count_word,
   output logic              pair_tms,
   output logic              pair_tdi
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW:0]       wsel;
   logic [PAIR_W-1:0] psel;
   logic [WORD_W-1:0] sel_word;
   logic [WORD_W-1:0] shifted;

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (wr_en && !lock && (wr_addr == AW'(i)))
            mem[i] <= wr_data;
      end
   end

   assign count_word = mem[0];
   assign wsel       = (AW + 1)'(rd_bit >> PAIR_W) + (AW + 1)'(1);
   assign psel       = rd_bit[PAIR_W-1:0];

   always_comb begin
      if (wsel < (AW + 1)'(DEPTH))
         sel_word = mem[wsel[AW-1:0]];
      else
         sel_word = '0;
   end

   assign shifted  = sel_word >> {psel, 1'b0};
   assign pair_tdi = shifted[0];
   assign pair_tms = shifted[1];
endmodule

// File: rtl/jwp_tck_gen.sv
module jwp_tck_gen #(
   parameter int HP_W  = 8,
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [HP_W-1:0]  half_period,
   input  logic [DLY_W-1:0] sample_delay,
   output logic             tck,
   output logic             samp,
   output logic             fall
);
   logic [HP_W-1:0] cnt;
   logic [HP_W-1:0] h_eff;
   logic [HP_W-1:0] d_ext;
   logic [HP_W-1:0] d_eff;
   logic            last;

   assign h_eff = (half_period == '0) ? HP_W'(1) : half_period;
   assign d_ext = HP_W'(sample_delay);
   assign d_eff = (d_ext >= h_eff) ? (h_eff - HP_W'(1)) : d_ext;
   assign last  = (cnt == (h_eff - HP_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         tck <= 1'b0;
      end else if (last) begin
         cnt <= '0;
         tck <= ~tck;
      end else begin
         cnt <= cnt + HP_W'(1);
      end
   end

   assign samp = run && tck && (cnt == d_eff);
   assign fall = run && tck && last;

   p_phase_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $stable(half_period)) |-> (cnt < h_eff));
endmodule

// File: rtl/jwp_tdo_pack.sv
module jwp_tdo_pack #(
   parameter int WORD_W   = 32,
   parameter int RES_BITS = 16,
   localparam int FW      = $clog2(RES_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              samp,
   input  logic              last,
   input  logic              tdo,
   output logic [WORD_W-1:0] res_word,
   output logic              res_valid
);
   logic [RES_BITS-1:0] shreg;
   logic [RES_BITS-1:0] nxt;
   logic [FW-1:0]       fill;

   always_comb begin
      nxt       = shreg;
      nxt[fill] = tdo;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg     <= '0;
         fill      <= '0;
         res_word  <= '0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         if (clr) begin
            shreg <= '0;
            fill  <= '0;
         end else if (samp) begin
            if (last || (fill == FW'(RES_BITS - 1))) begin
               res_word  <= WORD_W'(nxt);
               res_valid <= 1'b1;
               shreg     <= '0;
               fill      <= '0;
            end else begin
               shreg <= nxt;
               fill  <= fill + FW'(1);
            end
         end
      end
   end

   p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   p_fill_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (fill == '0));
endmodule

// File: rtl/jtag_word_player.sv
module jtag_word_player
   import jwp_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int DEPTH    = 16,
   parameter int RES_BITS = 16,
   parameter int HP_W     = 8,
   parameter int DLY_W    = 8,
   localparam int AW      = $clog2(DEPTH),
   localparam int CAP     = (DEPTH - 1) * (WORD_W / 2),
   localparam int BIDX_W  = $clog2(CAP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              start,
   input  logic [HP_W-1:0]   half_period,
   input  logic [DLY_W-1:0]  sample_delay,
   output logic              busy,
   output logic              done,
   output logic              tck,
   output logic              tms,
   output logic              tdi,
   input  logic              tdo,
   output logic [WORD_W-1:0] res_word,
   output logic              res_valid
);
   if (WORD_W % 2 != 0) begin : g_bad_word
      $error("WORD_W must be even");
   end
   if (RES_BITS > WORD_W || RES_BITS < 2) begin : g_bad_res
      $error("RES_BITS must lie in 2..WORD_W");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (DLY_W > HP_W) begin : g_bad_dly
      $error("DLY_W must not exceed HP_W");
   end
   if (BIDX_W > WORD_W) begin : g_bad_cap
      $error("capacity does not fit the count word");
   end
   if (CAP != int'(jwp_capacity(DEPTH, WORD_W))) begin : g_bad_cap2
      $error("capacity mismatch");
   end

   jwp_state_e        state;
   logic [BIDX_W-1:0] bit_idx;
   logic [BIDX_W-1:0] n_bits;
   logic [BIDX_W-1:0] rd_bit;
   logic [BIDX_W-1:0] cnt_cl;
   logic [WORD_W-1:0] count_word;
   logic              pair_tms;
   logic              pair_tdi;
   logic              running;
   logic              start_ok;
   logic              samp;
   logic              fall;
   logic              at_last;

   assign running  = (state == JWP_RUN);
   assign busy     = running;
   assign start_ok = start && !running;
   assign at_last  = (bit_idx == (n_bits - BIDX_W'(1)));
   assign rd_bit   = running ? (bit_idx + BIDX_W'(1)) : '0;
   assign cnt_cl   = (count_word > WORD_W'(CAP)) ? BIDX_W'(CAP) : count_word[BIDX_W-1:0];

   jwp_word_buf #(.WORD_W(WORD_W), .DEPTH(DEPTH), .BIDX_W(BIDX_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .lock(running), .rd_bit(rd_bit), .count_word(count_word),
      .pair_tms(pair_tms), .pair_tdi(pair_tdi)
   );

   jwp_tck_gen #(.HP_W(HP_W), .DLY_W(DLY_W)) u_tck (
      .clk(clk), .rst_n(rst_n), .run(running), .half_period(half_period),
      .sample_delay(sample_delay), .tck(tck), .samp(samp), .fall(fall)
   );

   jwp_tdo_pack #(.WORD_W(WORD_W), .RES_BITS(RES_BITS)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr(start_ok), .samp(samp), .last(at_last),
      .tdo(tdo), .res_word(res_word), .res_valid(res_valid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= JWP_IDLE;
         bit_idx <= '0;
         n_bits  <= '0;
         tms     <= 1'b0;
         tdi     <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!running) begin
            if (start) begin
               if (cnt_cl == '0) begin
                  done <= 1'b1;
               end else begin
                  state   <= JWP_RUN;
                  bit_idx <= '0;
                  n_bits  <= cnt_cl;
                  tms     <= pair_tms;
                  tdi     <= pair_tdi;
               end
            end
         end else if (fall) begin
            if (at_last) begin
               state <= JWP_IDLE;
               done  <= 1'b1;
            end else begin
               bit_idx <= bit_idx + BIDX_W'(1);
               tms     <= pair_tms;
               tdi     <= pair_tdi;
            end
         end
      end
   end

   p_pins_hold_at_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tck) |-> ($stable(tms) && $stable(tdi)));
   p_pins_move_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(tms) || !$stable(tdi)) |-> !tck);
   p_idle_clock_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tck);
   p_done_ends_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !tck));
   p_result_padded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_word[WORD_W-1:RES_BITS] == '0));
   p_bound_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((bit_idx < n_bits) && (n_bits <= BIDX_W'(CAP))));
endmodule

// File: tb/jtag_word_player_test.sv
module jtag_word_player_test;
   localparam int CLK_PERIOD = 10;
   localparam int WORD_W     = 32;
   localparam int DEPTH      = 4;
   localparam int AW         = $clog2(DEPTH);
   localparam int CAP        = (DEPTH - 1) * 16;
   localparam int NVEC       = 7;
   // count, half_period, sample_delay, seed
   localparam int VEC [NVEC][4] = '{
      '{1,  1, 0, 5},
      '{16, 1, 0, 7},
      '{17, 2, 1, 9},
      '{33, 3, 2, 12},
      '{5,  2, 7, 3},
      '{20, 0, 0, 4},
      '{60, 1, 0, 8}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [AW-1:0]     wr_addr = '0;
   logic [WORD_W-1:0] wr_data = '0;
   logic              start = 1'b0;
   logic [7:0]        half_period = 8'd1;
   logic [7:0]        sample_delay = 8'd0;
   logic              busy, done, tck, tms, tdi;
   logic              tdo = 1'b0;
   logic [WORD_W-1:0] res_word;
   logic              res_valid;

   int checks = 0;
   int errors = 0;

   jtag_word_player #(.WORD_W(WORD_W), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .start(start), .half_period(half_period), .sample_delay(sample_delay),
      .busy(busy), .done(done), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
      .res_word(res_word), .res_valid(res_valid)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] img(input int i, input int sd);
      return (32'h9E3779B9 * 32'(i + sd)) ^ (32'(sd) << 7);
   endfunction

   function automatic logic exp_tdo(input int b, input int sd);
      return 1'((b * 5 + sd + b / 3) & 1);
   endfunction

   task automatic run_job(input int cnt, input int hp, input int dl, input int sd, input bit poke);
      int heff, deff, neff, nres, rises, kres, low_run, high_run, hcnt, b;
      bit ptck, finished;
      logic [31:0] w, expw;
      heff = (hp == 0) ? 1 : hp;
      deff = (dl > heff - 1) ? heff - 1 : dl;
      neff = (cnt > CAP) ? CAP : cnt;
      nres = (neff + 15) / 16;
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = AW'(i);
         wr_data = (i == 0) ? 32'(cnt) : img(i, sd);
      end
      @(negedge clk);
      wr_en = 1'b0;
      half_period = 8'(hp); sample_delay = 8'(dl);
      start = 1'b1;
      rises = 0; kres = 0; low_run = 0; high_run = 0; hcnt = 0; b = 0;
      ptck = 1'b0; finished = 1'b0;
      for (int cyc = 0; cyc < 5000 && !finished; cyc++) begin
         @(negedge clk);
         if (cyc == 0) begin
            start = 1'b0;
            chk(busy == (neff > 0), "R2 R9 busy after start", busy, neff > 0);
         end
         if (poke && cyc == 2) begin
            wr_en = 1'b1; wr_addr = AW'(1); wr_data = ~img(1, sd); start = 1'b1;
         end
         if (poke && cyc == 3) begin
            wr_en = 1'b0; start = 1'b0;
         end
         if (tck) begin
            if (!ptck) begin
               b = rises;
               rises++;
               chk(low_run == heff, "R5 low phase length", low_run, heff);
               w = img(1 + b / 16, sd);
               chk(tdi == w[2 * (b % 16)], "R3 R11 tdi pair", tdi, w[2 * (b % 16)]);
               chk(tms == w[2 * (b % 16) + 1], "R3 R4 tms pair", tms, w[2 * (b % 16) + 1]);
               hcnt = 0; high_run = 0;
            end else begin
               hcnt++;
            end
            high_run++;
            tdo = (hcnt == deff) ? exp_tdo(b, sd) : ~exp_tdo(b, sd);
         end else begin
            if (ptck) begin
               chk(high_run == heff, "R5 high phase length", high_run, heff);
               low_run = 0;
            end
            low_run++;
            tdo = 1'b0;
         end
         if (res_valid) begin
            expw = '0;
            for (int j = 0; j < 16; j++)
               if (kres * 16 + j < neff) expw[j] = exp_tdo(kres * 16 + j, sd);
            chk(res_word == expw, "R6 R7 R8 result word", res_word, expw);
            kres++;
         end
         if (done) begin
            finished = 1'b1;
            chk(rises == neff, "R2 R10 tck pulse count", rises, neff);
            chk(kres == nres, "R7 R8 R9 result count", kres, nres);
            chk(!busy && !tck, "R2 idle at done", {busy, tck}, 0);
            if (neff > 0) chk(ptck == 1'b1, "R2 done with last fall", ptck, 1);
         end
         ptck = tck;
      end
      chk(finished, "R2 done seen", finished, 1);
      @(negedge clk);
      chk(!done, "R2 done one cycle", done, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk({tck, tms, tdi, busy, done, res_valid} == 6'b0, "R1 during reset",
          {tck, tms, tdi, busy, done, res_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({tck, tms, tdi, busy, done, res_valid} == 6'b0, "R1 after reset",
          {tck, tms, tdi, busy, done, res_valid}, 0);
      for (int v = 0; v < NVEC; v++)
         run_job(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);
      // R9 zero count
      run_job(0, 2, 0, 6, 1'b0);
      // R11 write and start during a run
      run_job(20, 2, 1, 11, 1'b1);
      // R6 delay at last slot of high phase
      run_job(9, 4, 3, 2, 1'b0);
      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule